// File: doc/BRIEF.md
# Maskable Interrupt Status Unit

This block gathers single-cycle event pulses from several hardware sources into a 32-bit status word and condenses the pending, enabled bits into one interrupt line. Each hardware source owns a fixed status bit. A bit that an event sets stays set until software clears it. Software reaches the block through a small register port with three registers: the status word, a set word, and a mask word.

Writing ones to the set word forces the matching status bits, which lets software inject interrupts. Writing ones to the status word clears the matching bits. The mask works with enable-low polarity, so a mask bit of 0 lets its status bit reach the interrupt line. Reset leaves every source masked and the status word empty. The interrupt output is taken from a flip-flop, so it follows the pending state one clock later.

Top module: `irq_status_unit`

## Requirements
- R1: After synchronous reset (`rst` high), status reads 0x00000000, mask reads 0xFFFFFFFF and `irqOut` is 0.
- R2: A one-cycle pulse on an event input sets its status bit at the next clock edge, and the bit stays set until it is cleared. The bit positions are: capture start 31, stream end 30, VBI capture 29, encoder DMA done 27, data request 22, decoder DMA done 20, link-list error 18.
- R3: A write to address 1 (set word) sets every status bit whose data bit is 1 and leaves the other bits unchanged. A read of address 1 returns 0.
- R4: A write to address 0 (status) clears every status bit whose data bit is 1 and leaves the bits written with 0 unchanged. A read of address 0 returns the status word.
- R5: When an event and a clear write hit the same status bit in the same cycle, the bit is set after the edge.
- R6: A write to address 2 loads the mask, and a read of address 2 returns it. A status bit whose mask bit is 1 never raises `irqOut`.
- R7: `irqOut` is a register. After each edge it equals the OR over all bits of (status AND NOT mask), using the values held before that edge.
- R8: A write to address 3 changes no register, and a read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWr | input | 1 | Write strobe of the register port |
| regAddr | input | 2 | Write word address |
| regWrData | input | 32 | Write data |
| rdAddr | input | 2 | Read word address |
| rdData | output | 32 | Read data, combinational from rdAddr |
| evCaptureStart | input | 1 | Capture-start event pulse |
| evStreamEnd | input | 1 | End-of-stream event pulse |
| evVbiCapture | input | 1 | VBI-capture event pulse |
| evEncDmaDone | input | 1 | Encoder-side DMA-complete pulse |
| evDataRequest | input | 1 | Data-request event pulse |
| evDecDmaDone | input | 1 | Decoder-side DMA-complete pulse |
| evLinkListErr | input | 1 | DMA link-list error pulse |
| irqOut | output | 1 | Registered interrupt line |

## Verification
Assertions check four things on every cycle: events and set writes are never lost, cleared bits drop unless an event hits them in the same cycle, the status and mask hold steady when nothing touches them, and the interrupt line follows the enabled-pending state. Some behaviour only the bench scenarios can show: the bit position of each event source, that the set and unmapped addresses read as zero, that a write to address 3 changes nothing, and that a clear write racing an event keeps the bit set. The bench's reference model is compared on every clock.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;

  localparam int REG_ADDR_W = 2;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_SET    = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  // Strobes handed from the control decoder to the datapath.
  typedef struct packed {
    logic    clearWr;
    logic    setWr;
    logic    maskWr;
    regSel_e rdSel;
  } regStrobe_t;

  // Status bit assigned to each hardware event source.
  localparam int BIT_CAPTURE_START = 31;
  localparam int BIT_STREAM_END    = 30;
  localparam int BIT_VBI_CAPTURE   = 29;
  localparam int BIT_ENC_DMA_DONE  = 27;
  localparam int BIT_DATA_REQUEST  = 22;
  localparam int BIT_DEC_DMA_DONE  = 20;
  localparam int BIT_LINK_LIST_ERR = 18;

endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_unit_pkg::*;
#(
  parameter int ADDR_W = REG_ADDR_W
) (
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output regStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] ADDR_STATUS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_SET    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_MASK   = ADDR_W'(2);

  always_comb begin
    strobe.clearWr = regWr && (regAddr == ADDR_STATUS);
    strobe.setWr   = regWr && (regAddr == ADDR_SET);
    strobe.maskWr  = regWr && (regAddr == ADDR_MASK);
    if (rdAddr == ADDR_STATUS)    strobe.rdSel = SEL_STATUS;
    else if (rdAddr == ADDR_SET)  strobe.rdSel = SEL_SET;
    else if (rdAddr == ADDR_MASK) strobe.rdSel = SEL_MASK;
    else                          strobe.rdSel = SEL_NONE;
  end

  // The three write strobes can never fire together.
  always_comb begin
    assert_one_write_R8: assert ($onehot0({strobe.clearWr, strobe.setWr, strobe.maskWr}));
  end

endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_unit_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] eventVec,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);

  logic [DATA_W-1:0] status;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] clearBits;
  logic [DATA_W-1:0] setBits;
  logic [DATA_W-1:0] statusNext;
  logic              irqReg;

  assign clearBits  = strobe.clearWr ? wrData : '0;
  assign setBits    = strobe.setWr   ? wrData : '0;
  // Events are ORed in after the clear, so an event wins over a clear.
  assign statusNext = (status & ~clearBits) | setBits | eventVec;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      mask   <= '1;
      irqReg <= 1'b0;
    end else begin
      status <= statusNext;
      if (strobe.maskWr) mask <= wrData;
      irqReg <= |(status & ~mask);
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_STATUS: rdData = status;
      SEL_MASK:   rdData = mask;
      default:    rdData = '0;
    endcase
  end

  assign irqOut = irqReg;

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) && !rst |-> (status == '0) && (mask == '1) && !irqOut);

  assert_event_latched_R2: assert property (@(posedge clk) disable iff (rst)
    (eventVec != '0) |=> ((status & $past(eventVec)) == $past(eventVec)));

  assert_set_write_R3: assert property (@(posedge clk) disable iff (rst)
    strobe.setWr |=> ((status & $past(wrData)) == $past(wrData)));

  assert_clear_write_R4: assert property (@(posedge clk) disable iff (rst)
    strobe.clearWr |=> ((status & $past(wrData) & ~$past(eventVec)) == '0));

  assert_event_beats_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (strobe.clearWr && ((wrData & eventVec) != '0))
      |=> ((status & $past(wrData & eventVec)) == $past(wrData & eventVec)));

  assert_status_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!strobe.clearWr && !strobe.setWr && eventVec == '0) |=> $stable(status));

  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !strobe.maskWr |=> $stable(mask));

  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (rst)
    ((status & ~mask) != '0) |=> irqOut);

  assert_irq_fall_R6: assert property (@(posedge clk) disable iff (rst)
    ((status & ~mask) == '0) |=> !irqOut);

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_unit_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = REG_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              evCaptureStart,
  input  logic              evStreamEnd,
  input  logic              evVbiCapture,
  input  logic              evEncDmaDone,
  input  logic              evDataRequest,
  input  logic              evDecDmaDone,
  input  logic              evLinkListErr,
  output logic              irqOut
);

  regStrobe_t        strobe;
  logic [DATA_W-1:0] eventVec;

  always_comb begin
    eventVec                    = '0;
    eventVec[BIT_CAPTURE_START] = evCaptureStart;
    eventVec[BIT_STREAM_END]    = evStreamEnd;
    eventVec[BIT_VBI_CAPTURE]   = evVbiCapture;
    eventVec[BIT_ENC_DMA_DONE]  = evEncDmaDone;
    eventVec[BIT_DATA_REQUEST]  = evDataRequest;
    eventVec[BIT_DEC_DMA_DONE]  = evDecDmaDone;
    eventVec[BIT_LINK_LIST_ERR] = evLinkListErr;
  end

  irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regWr   (regWr),
    .regAddr (regAddr),
    .rdAddr  (rdAddr),
    .strobe  (strobe)
  );

  irq_datapath #(.DATA_W(DATA_W)) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .wrData   (regWrData),
    .eventVec (eventVec),
    .rdData   (rdData),
    .irqOut   (irqOut)
  );

endmodule

// File: tb/irq_status_unit_bench.sv
module irq_status_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWr = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [6:0]  ev = '0;  // {capStart, streamEnd, vbi, encDma, dataReq, decDma, llErr}
  logic        irqOut;

  int    checks = 0;
  int    errors = 0;
  string tagNow = "R1";
  bit    done = 0;

  // Reference model state.
  logic [31:0] mStatus;
  logic [31:0] mMask;
  logic        mIrq;

  always #5 clk = ~clk;

  irq_status_unit u_irq_status_unit (
    .clk(clk), .rst(rst), .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .evCaptureStart(ev[6]), .evStreamEnd(ev[5]), .evVbiCapture(ev[4]),
    .evEncDmaDone(ev[3]), .evDataRequest(ev[2]), .evDecDmaDone(ev[1]),
    .evLinkListErr(ev[0]), .irqOut(irqOut)
  );

  function automatic logic [31:0] evWord(input logic [6:0] e);
    logic [31:0] w = '0;
    w[31] = e[6]; w[30] = e[5]; w[29] = e[4]; w[27] = e[3];
    w[22] = e[2]; w[20] = e[1]; w[18] = e[0];
    return w;
  endfunction

  always @(posedge clk) begin
    logic [31:0] nxt;
    if (rst) begin
      mStatus = '0; mMask = '1; mIrq = 1'b0;
    end else begin
      mIrq = (mStatus & ~mMask) != 0;
      nxt = mStatus;
      if (regWr && regAddr == 2'd0) nxt = nxt & ~regWrData;
      if (regWr && regAddr == 2'd1) nxt = nxt | regWrData;
      nxt = nxt | evWord(ev);
      if (regWr && regAddr == 2'd2) mMask = regWrData;
      mStatus = nxt;
    end
  end

  function automatic logic [31:0] expRead(input logic [1:0] a);
    if (a == 2'd0) return mStatus;
    if (a == 2'd2) return mMask;
    return '0;
  endfunction

  task automatic compareNow();
    checks++;
    if (rdData !== expRead(rdAddr)) begin
      errors++;
      $display("FAIL %s rdData addr %0d actual %h expected %h", tagNow, rdAddr, rdData, expRead(rdAddr));
    end
    checks++;
    if (irqOut !== mIrq) begin
      errors++;
      $display("FAIL %s irqOut actual %0b expected %0b", tagNow, irqOut, mIrq);
    end
  endtask

  task automatic doCycle(input string tag, input logic wr, input logic [1:0] wa,
                         input logic [31:0] wd, input logic [6:0] e, input logic [1:0] ra);
    tagNow = tag; regWr = wr; regAddr = wa; regWrData = wd; ev = e; rdAddr = ra;
    @(negedge clk);
    compareNow();
  endtask

  task automatic idle(input string tag, input logic [1:0] ra);
    doCycle(tag, 1'b0, 2'd0, '0, '0, ra);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state, R3 and R8 zero reads
    idle("R1", 2'd0);
    idle("R1", 2'd2);
    idle("R3", 2'd1);
    idle("R8", 2'd3);
    // R2 each event singly, all masked so no interrupt (R6)
    for (int i = 0; i < 7; i++) begin
      doCycle("R2", 1'b0, 2'd0, '0, 7'(1 << i), 2'd0);
    end
    idle("R6", 2'd0);
    idle("R6", 2'd0);
    // R4 clear with zeros: no change, then clear two bits
    doCycle("R4", 1'b1, 2'd0, 32'h0, '0, 2'd0);
    doCycle("R4", 1'b1, 2'd0, 32'h8000_0000 | 32'h0004_0000, '0, 2'd0);
    // R3 set write
    doCycle("R3", 1'b1, 2'd1, 32'h0000_0005, '0, 2'd0);
    idle("R3", 2'd1);
    // R6 mask write and readback, R7 interrupt rise
    doCycle("R6", 1'b1, 2'd2, 32'hFFFF_FFFE, '0, 2'd2);
    idle("R7", 2'd0);
    idle("R7", 2'd0);
    // R7 interrupt fall after clearing bit 0
    doCycle("R7", 1'b1, 2'd0, 32'h0000_0001, '0, 2'd0);
    idle("R7", 2'd0);
    idle("R7", 2'd0);
    // R5 clear and event on bit 27 together
    doCycle("R5", 1'b1, 2'd0, 32'hFFFF_FFFF, 7'b000_1000, 2'd0);
    idle("R5", 2'd0);
    // R6 unmask bit 27 only: interrupt rises
    doCycle("R6", 1'b1, 2'd2, ~(32'h1 << 27), '0, 2'd2);
    idle("R7", 2'd0);
    idle("R7", 2'd0);
    // R8 unmapped write changes nothing
    doCycle("R8", 1'b1, 2'd3, 32'hFFFF_FFFF, '0, 2'd3);
    idle("R8", 2'd0);
    idle("R8", 2'd2);
    // R6 mask everything again: interrupt falls, status kept
    doCycle("R6", 1'b1, 2'd2, 32'hFFFF_FFFF, '0, 2'd0);
    idle("R6", 2'd0);
    idle("R6", 2'd0);
    // R1 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    idle("R1", 2'd0);
    idle("R1", 2'd2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule